// File: doc/BRIEF.md
# Flash Block-Protection Window Checker

This block lives inside a serial NOR flash device model. It turns the protection fields of the 8-bit status register into a protected address window, given as a base address and a byte length. It then tests every program or erase request against that window. The window is a power-of-two fraction of the array. A 3-bit size code selects the fraction, and a placement bit can anchor the window at the low end of the array instead of the high end.

The surrounding model feeds the block the live status register, the write-protect pin level, and each request as an address, a length and a one-cycle valid strobe. In return the block gives a registered window, a registered "request blocked" flag and a registered flag that tells the model to refuse status-register writes. The array size is set by `ADDR_W`, so the array holds 2^ADDR_W bytes; `ADDR_W` must be at least 7. `TB_EN` selects whether the placement bit is honoured.

Top module: `prot_range_guard`

## Requirements
- R1: The size code is status bits [4:2]. For a code c from 1 to 6, the window length is 2^(ADDR_W-7+c) bytes, so an 8 MB array gives 128 KB for c=1, 1 MB for c=4 and 4 MB for c=6.
- R2: Code 0 protects nothing: window base 0, length 0.
- R3: Code 7 protects the whole array (base 0, length 2^ADDR_W), whatever the placement bit holds.
- R4: With TB_EN=1, status bit 5 selects placement. 0 places the window at the top, where it ends at the last array address (base = 2^ADDR_W − length). 1 places it at the bottom, where it starts at address 0.
- R5: With TB_EN=0, status bit 5 has no effect and the window is always placed at the top.
- R6: `prot_base` and `prot_len` reflect the status register sampled at the previous rising clock edge.
- R7: `req_blocked` is high in the cycle after a `req_valid` cycle when the request bytes [req_addr, req_addr+req_len−1] share at least one address with the window. The request end is compared without wrap-around, so a request running past the array end still counts.
- R8: `req_blocked` is low in the cycle after any cycle with `req_valid` low or with `req_len` zero.
- R9: `sr_write_inhibit` is high in the cycle after a cycle in which status bit 7 and `wp_asserted` are both high, and low otherwise.
- R10: While `rst` is high at a rising edge, all outputs are 0 at the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_reg | input | 8 | Current status register contents |
| wp_asserted | input | 1 | Write-protect pin asserted (high = active) |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | ADDR_W+1 | Request length in bytes |
| prot_base | output | ADDR_W | Registered window base address |
| prot_len | output | ADDR_W+1 | Registered window length in bytes |
| req_blocked | output | 1 | Request overlapped the window (one cycle later) |
| sr_write_inhibit | output | 1 | Status-register writes must be refused |

## Verification
The bench walks all sixteen size-code and placement combinations on two instances, one that honours placement and one that does not. An off-by-one in the shift would show up as a window twice or half the right size. A placement bit leaking into the second instance would show up as a bottom window where a top one belongs. Directed requests end exactly one byte before the window, touch its first or last byte, run past the array end, or have zero length. A design with an inclusive/exclusive slip at either edge, or with a wrapping end sum, would flag the clean neighbour or miss the overrun. Random status, pin and request traffic then checks the inhibit flag and the overlap result against bench reference functions.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  // Status register field positions decoded by this block
  localparam int unsigned SZ_CODE_LSB = 2;
  localparam int unsigned SZ_CODE_W   = 3;
  localparam int unsigned PLACE_BIT   = 5;
  localparam int unsigned LOCK_BIT    = 7;

  typedef enum logic {
    PLACE_TOP    = 1'b0,
    PLACE_BOTTOM = 1'b1
  } place_e;
endpackage

// File: rtl/prot_window_decode.sv
module prot_window_decode
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter bit          TB_EN  = 1'b1
) (
  input  logic [SZ_CODE_W-1:0] size_code,
  input  logic                 place_bit,
  output logic [ADDR_W-1:0]    win_base,
  output logic [ADDR_W:0]      win_len
);
  localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [SZ_CODE_W-1:0] CODE_ALL = '1;

  place_e place;
  logic [ADDR_W:0] top_base;

  assign place = (TB_EN && place_bit) ? PLACE_BOTTOM : PLACE_TOP;

  always_comb begin
    win_len  = '0;
    win_base = '0;
    top_base = '0;
    if (size_code == CODE_ALL) begin
      win_len = FULL;
    end else if (size_code != '0) begin
      win_len  = FULL >> (CODE_ALL - size_code);
      top_base = FULL - win_len;
      if (place == PLACE_TOP)
        win_base = top_base[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/prot_overlap_check.sv
module prot_overlap_check #(
  parameter int unsigned ADDR_W = 23
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W:0]   req_len,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W:0]   win_len,
  output logic              hit
);
  // One spare bit so neither end sum can wrap
  localparam int unsigned SW = ADDR_W + 2;

  logic [SW-1:0] req_lo, req_end, win_lo, win_end;

  always_comb begin
    req_lo  = SW'(req_addr);
    req_end = SW'(req_addr) + SW'(req_len);
    win_lo  = SW'(win_base);
    win_end = SW'(win_base) + SW'(win_len);
    hit = (req_len != '0) && (win_len != '0) &&
          (req_lo < win_end) && (req_end > win_lo);
  end
endmodule

// File: rtl/prot_range_guard.sv
module prot_range_guard
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter bit          TB_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        status_reg,
  input  logic              wp_asserted,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W:0]   req_len,
  output logic [ADDR_W-1:0] prot_base,
  output logic [ADDR_W:0]   prot_len,
  output logic              req_blocked,
  output logic              sr_write_inhibit
);
  logic [ADDR_W-1:0] dec_base;
  logic [ADDR_W:0]   dec_len;
  logic              ovl_hit;
  logic              unused_sr_bits;

  assign unused_sr_bits = ^{status_reg[1:0], status_reg[6]};

  prot_window_decode #(.ADDR_W(ADDR_W), .TB_EN(TB_EN)) decode_i (
    .size_code (status_reg[SZ_CODE_LSB +: SZ_CODE_W]),
    .place_bit (status_reg[PLACE_BIT]),
    .win_base  (dec_base),
    .win_len   (dec_len)
  );

  // Requests are judged against the window of the same cycle's status
  prot_overlap_check #(.ADDR_W(ADDR_W)) overlap_i (
    .req_addr (req_addr),
    .req_len  (req_len),
    .win_base (dec_base),
    .win_len  (dec_len),
    .hit      (ovl_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_base        <= '0;
      prot_len         <= '0;
      req_blocked      <= 1'b0;
      sr_write_inhibit <= 1'b0;
    end else begin
      prot_base        <= dec_base;
      prot_len         <= dec_len;
      req_blocked      <= req_valid && ovl_hit;
      sr_write_inhibit <= status_reg[LOCK_BIT] && wp_asserted;
    end
  end
endmodule

// File: rtl/prot_range_guard_chk.sv
module prot_range_guard_chk #(
  parameter int unsigned ADDR_W = 23
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        status_reg,
  input logic              wp_asserted,
  input logic              req_valid,
  input logic [ADDR_W:0]   req_len,
  input logic [ADDR_W-1:0] prot_base,
  input logic [ADDR_W:0]   prot_len,
  input logic              req_blocked,
  input logic              sr_write_inhibit
);
  localparam logic [ADDR_W+1:0] FULL = {2'b01, {ADDR_W{1'b0}}};

  // R1
  len_pow2_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(prot_len) <= 1);

  // R2
  code_none_chk: assert property (@(posedge clk) disable iff (rst)
    (status_reg[4:2] == 3'b000) |=> (prot_len == '0 && prot_base == '0));

  // R3
  code_all_chk: assert property (@(posedge clk) disable iff (rst)
    (status_reg[4:2] == 3'b111) |=> (prot_len == FULL[ADDR_W:0] && prot_base == '0));

  // R4
  window_fit_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, prot_len} + {2'b00, prot_base}) <= FULL);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !req_blocked);

  // R8
  empty_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_len == '0) |=> !req_blocked);

  // R9
  inhibit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (status_reg[7] && wp_asserted) |=> sr_write_inhibit);

  // R9
  inhibit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(status_reg[7] && wp_asserted) |=> !sr_write_inhibit);
endmodule

bind prot_range_guard prot_range_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .status_reg       (status_reg),
  .wp_asserted      (wp_asserted),
  .req_valid        (req_valid),
  .req_len          (req_len),
  .prot_base        (prot_base),
  .prot_len         (prot_len),
  .req_blocked      (req_blocked),
  .sr_write_inhibit (sr_write_inhibit)
);

// File: tb/prot_range_guard_tb_top.sv
module prot_range_guard_tb_top;
  localparam int unsigned ADDR_W = 23;
  localparam longint FULL = longint'(1) << ADDR_W;

  logic              clk = 1'b0;
  logic              rst;
  logic [7:0]        status_reg;
  logic              wp_asserted;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [ADDR_W:0]   req_len;

  logic [ADDR_W-1:0] base_a, base_b;
  logic [ADDR_W:0]   len_a, len_b;
  logic              blk_a, blk_b, inh_a, inh_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  prot_range_guard #(.ADDR_W(ADDR_W), .TB_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .status_reg(status_reg), .wp_asserted(wp_asserted),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .prot_base(base_a), .prot_len(len_a), .req_blocked(blk_a),
    .sr_write_inhibit(inh_a)
  );

  prot_range_guard #(.ADDR_W(ADDR_W), .TB_EN(1'b0)) dut_notb_i (
    .clk(clk), .rst(rst), .status_reg(status_reg), .wp_asserted(wp_asserted),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .prot_base(base_b), .prot_len(len_b), .req_blocked(blk_b),
    .sr_write_inhibit(inh_b)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Window length: 2^(ADDR_W-7+code), zero for code 0 (R1, R2, R3)
  function automatic longint ref_len(input int code);
    if (code == 0) return 0;
    return longint'(1) << (ADDR_W - 7 + code);
  endfunction

  function automatic longint ref_base(input int code, input bit place, input bit honour);
    if (code == 0 || (place && honour)) return 0;
    return FULL - ref_len(code);
  endfunction

  function automatic bit ref_hit(input longint a, input longint l,
                                 input longint b, input longint w);
    return (l != 0) && (w != 0) && (a < b + w) && (a + l > b);
  endfunction

  function automatic string win_tag(input int code);
    if (code == 0) return "R2";
    if (code == 7) return "R3";
    return "R1";
  endfunction

  // Drive one cycle of inputs, then check every output one edge later
  task automatic apply(input logic [7:0] sr, input logic wp, input logic v,
                       input longint a, input longint l);
    int  code;
    bit  pl;
    longint ba, bb, wa, wb;
    string blk_tag;
    code = int'(sr[4:2]);
    pl   = sr[5];
    status_reg  = sr;
    wp_asserted = wp;
    req_valid   = v;
    req_addr    = a[ADDR_W-1:0];
    req_len     = l[ADDR_W:0];
    @(negedge clk);
    wa = ref_len(code);
    ba = ref_base(code, pl, 1'b1);
    bb = ref_base(code, pl, 1'b0);
    wb = wa;
    chk(win_tag(code), "len (R6)", longint'(len_a), wa);
    chk(pl ? "R4" : win_tag(code), "base", longint'(base_a), ba);
    chk("R5", "base no-placement", longint'(base_b), bb);
    chk("R5", "len no-placement", longint'(len_b), wb);
    blk_tag = (v && l != 0) ? "R7" : "R8";
    chk(blk_tag, "blocked", longint'(blk_a), longint'(v && ref_hit(a, l, ba, wa)));
    chk(blk_tag, "blocked no-placement", longint'(blk_b),
        longint'(v && ref_hit(a, l, bb, wb)));
    chk("R9", "inhibit", longint'(inh_a), longint'(sr[7] && wp));
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst = 1'b1;
    status_reg = 8'hFF; wp_asserted = 1'b1; req_valid = 1'b1;
    req_addr = '0; req_len = '1;
    repeat (3) @(negedge clk);
    chk("R10", "base in reset", longint'(base_a), 0);
    chk("R10", "len in reset", longint'(len_a), 0);
    chk("R10", "blocked in reset", longint'(blk_a), 0);
    chk("R10", "inhibit in reset", longint'(inh_a), 0);
    rst = 1'b0;

    // Sweep every size code and placement bit
    for (int pl = 0; pl < 2; pl++)
      for (int code = 0; code < 8; code++)
        apply({1'b1, 1'b0, pl[0], code[2:0], 2'b00}, code[0], 1'b0, 0, 0);

    // R7: top window of code 1 is [0x7E0000, 0x7FFFFF]
    apply(8'h04, 1'b0, 1'b1, 64'h7E0000 - 64'h100, 64'h100);   // ends one byte short
    apply(8'h04, 1'b0, 1'b1, 64'h7E0000 - 64'h100, 64'h101);   // touches first byte
    apply(8'h04, 1'b0, 1'b1, 64'h7FFFFF, 64'h10);              // runs past array end
    apply(8'h04, 1'b0, 1'b1, 64'h7E0000, 0);                   // R8 zero length
    apply(8'h04, 1'b0, 1'b0, 64'h7E0000, 64'h40);              // R8 not valid
    // R4/R7: bottom window of code 1 is [0, 0x1FFFF]
    apply(8'h24, 1'b1, 1'b1, 64'h20000, 64'h4);                // just above window
    apply(8'h24, 1'b1, 1'b1, 64'h1FFFF, 64'h1);                // last window byte
    apply(8'hBC, 1'b1, 1'b1, 64'h0, FULL);                     // R3 whole array

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      longint a, l;
      r = $urandom;
      a = longint'($urandom) & (FULL - 1);
      case ($urandom % 4)
        0: l = 0;
        1: l = longint'($urandom % 64) + 1;
        2: l = longint'($urandom) & (FULL - 1);
        default: l = longint'($urandom % 32'h40000) + 1;
      endcase
      apply(r[7:0], r[8], (r[10:9] != 2'b00), a, l);
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule